// File: doc/BRIEF.md
# Priority Interrupt Vector Arbiter

This block carries out the arbitration and vector fetch behind a one-byte vectored-interrupt instruction in a small 8-bit controller. When the sequencer pulses `start_i`, the block takes in the address of that instruction. One cycle later it takes in the interrupt request lines: thirteen maskable sources, each with an enable and a pending bit, and a trap pending flag. It picks the highest-ranked active request and turns its rank into an even table offset between E0 and FE. It then reads a two-byte vector from program memory and returns a 15-bit jump target with a one-cycle `done_o` pulse.

The table page is the upper part of the instruction address. When the instruction sits on the last byte of a page (low byte FF), the next page is used instead. The vector's high byte is read first, from the even address. The low byte follows from the odd address. Bit 7 of the high byte is dropped, because program space is 32 KB. If no maskable source is both enabled and pending and the trap flag is clear, the default entry at offset E0 is used. Rank 14 (offset FC) is reserved. It is held inactive inside the encoder so that every other offset stays where it is.

The state machine has six states. `ST_IDLE` moves to `ST_ARB` when `start_i` is high; it latches the page at that transition. `ST_ARB` always moves to `ST_RD_HI` and latches the offset on the way. `ST_RD_HI` moves to `ST_RD_LO`, which moves to `ST_CAPTURE`. `ST_CAPTURE` moves to `ST_DONE`, and `ST_DONE` returns to `ST_IDLE`. Every transition after `ST_IDLE` is unconditional.

Top module: `vecarb_top`

## Requirements
- R1: While reset is active and after it is released, `busy_o`, `done_o` and `mem_rd_o` are all 0 until a start is accepted.
- R2: `start_i` is accepted only when the block is idle. `busy_o` is 1 from the next cycle until the cycle after `done_o`. A `start_i` pulse while busy starts no further reads and produces no further `done_o` pulse.
- R3: The request lines are sampled once, in the cycle after the accepted start. Changes to them from the following cycle on do not alter the selected vector.
- R4: Maskable source j (bit j of `irq_en_i`/`irq_pend_i`, j = 0..12) has rank j+1 and table offset E2 + 2·j. Among qualifying sources the highest j wins. Offset FC (rank 14) is never produced.
- R5: When `trap_pend_i` is 1 at the sampling cycle, offset FE is used, regardless of any maskable request.
- R6: A maskable source qualifies only if both its enable bit and its pending bit are 1. With no qualifying source and no trap, offset E0 is used.
- R7: The table page is bits 14:8 of `instr_addr_i`, captured when start is accepted. If bits 7:0 of that address are FF, the page is those upper bits plus one, wrapping 7F to 00.
- R8: Exactly two memory reads are issued, in consecutive cycles: first {page, offset}, then {page, offset+1}. Read data is expected one cycle after each request.
- R9: `target_o` = {bits 6:0 of the byte from the even address, byte from the odd address}. It is valid while `done_o` is high, and `done_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe from the instruction sequencer |
| instr_addr_i | input | 15 | Address of the vectored-interrupt instruction |
| irq_en_i | input | 13 | Enable bit per maskable source, bit j has rank j+1 |
| irq_pend_i | input | 13 | Pending bit per maskable source |
| trap_pend_i | input | 1 | Trap pending flag (top rank) |
| mem_rd_o | output | 1 | Program-memory read request |
| mem_addr_o | output | 15 | Program-memory read address |
| mem_rdata_i | input | 8 | Read data, valid one cycle after the request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse, target valid |
| target_o | output | 15 | Fetched jump target |

## Verification
The assertions assume that the request lines and `instr_addr_i` are stable during the sampling cycle and the cycle before it. They also assume memory data arrives exactly one cycle after each request. The bench drives inputs only on falling edges and holds the requests through the sampling cycle. Its memory model answers every read on the next rising edge, with a pattern computed from the address. The bench deliberately changes the requests, and pulses start again, only after the sampling cycle has passed. That keeps the stimulus inside those assumptions while still probing R2 and R3.

// File: rtl/vecarb_pkg.sv
package vecarb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_RD_HI,
        ST_RD_LO,
        ST_CAPTURE,
        ST_DONE
    } vis_state_e;

    localparam int unsigned NUM_RANK   = 16;
    localparam logic [7:0]  TABLE_BASE = 8'hE0;
    localparam int unsigned BYTE_W     = 8;
endpackage

// File: rtl/vecarb_prio_enc.sv
module vecarb_prio_enc #(
    parameter int unsigned NUM_MASK = 13,
    parameter int unsigned NUM_RANK = 16,
    parameter logic [7:0]  BASE     = 8'hE0
) (
    input  logic                trap_i,
    input  logic [NUM_MASK-1:0] req_i,
    output logic [7:0]          offset_o
);
    localparam int unsigned IDX_W = $clog2(NUM_RANK);

    logic [NUM_RANK-1:0] ranked;
    logic [IDX_W-1:0]    win_idx;

    // rank 0 is the default entry and always present
    assign ranked[0] = 1'b1;

    genvar g;
    generate
        for (g = 0; g < NUM_MASK; g++) begin : g_mask
            assign ranked[g+1] = req_i[g];
        end
        for (g = NUM_MASK + 1; g < NUM_RANK - 1; g++) begin : g_rsv
            assign ranked[g] = 1'b0;
        end
    endgenerate

    assign ranked[NUM_RANK-1] = trap_i;

    always_comb begin
        win_idx = '0;
        for (int r = 0; r < NUM_RANK; r++) begin
            if (ranked[r]) begin
                win_idx = IDX_W'(r);
            end
        end
    end

    assign offset_o = BASE + 8'({win_idx, 1'b0});
endmodule

// File: rtl/vecarb_page_sel.sv
module vecarb_page_sel #(
    parameter int unsigned ADDR_W = 15
) (
    input  logic [ADDR_W-1:0] instr_addr_i,
    output logic [ADDR_W-9:0] page_o
);
    localparam int unsigned PAGE_W = ADDR_W - 8;

    logic last_byte;

    assign last_byte = &instr_addr_i[7:0];
    assign page_o    = instr_addr_i[ADDR_W-1:8] + PAGE_W'(last_byte);
endmodule

// File: rtl/vecarb_top.sv
module vecarb_top #(
    parameter int unsigned ADDR_W   = 15,
    parameter int unsigned NUM_MASK = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [ADDR_W-1:0]   instr_addr_i,
    input  logic [NUM_MASK-1:0] irq_en_i,
    input  logic [NUM_MASK-1:0] irq_pend_i,
    input  logic                trap_pend_i,
    output logic                mem_rd_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    input  logic [7:0]          mem_rdata_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [ADDR_W-1:0]   target_o
);
    import vecarb_pkg::*;

    localparam int unsigned PAGE_W = ADDR_W - BYTE_W;

    vis_state_e          state_q, state_d;
    logic [PAGE_W-1:0]   page_q, page_w;
    logic [7:0]          off_q, off_w;
    logic [PAGE_W-1:0]   hi_q;
    logic [ADDR_W-1:0]   target_q;
    logic [NUM_MASK-1:0] qual_req;

    assign qual_req = irq_en_i & irq_pend_i;

    vecarb_prio_enc #(
        .NUM_MASK (NUM_MASK),
        .NUM_RANK (NUM_RANK),
        .BASE     (TABLE_BASE)
    ) enc_i (
        .trap_i   (trap_pend_i),
        .req_i    (qual_req),
        .offset_o (off_w)
    );

    vecarb_page_sel #(
        .ADDR_W (ADDR_W)
    ) page_i (
        .instr_addr_i (instr_addr_i),
        .page_o       (page_w)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_ARB;
            ST_ARB:     state_d = ST_RD_HI;
            ST_RD_HI:   state_d = ST_RD_LO;
            ST_RD_LO:   state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q   <= '0;
            off_q    <= TABLE_BASE;
            hi_q     <= '0;
            target_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                page_q <= page_w;
            end
            if (state_q == ST_ARB) begin
                off_q <= off_w;
            end
            if (state_q == ST_RD_LO) begin
                hi_q <= mem_rdata_i[PAGE_W-1:0];
            end
            if (state_q == ST_CAPTURE) begin
                target_q <= {hi_q, mem_rdata_i};
            end
        end
    end

    // outputs
    always_comb begin
        mem_rd_o   = 1'b0;
        mem_addr_o = {page_q, off_q};
        busy_o     = 1'b1;
        done_o     = 1'b0;
        unique case (state_q)
            ST_IDLE:    busy_o = 1'b0;
            ST_ARB:     ;
            ST_RD_HI:   mem_rd_o = 1'b1;
            ST_RD_LO: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = {page_q, off_q | 8'h01};
            end
            ST_CAPTURE: ;
            ST_DONE:    done_o = 1'b1;
            default:    busy_o = 1'b0;
        endcase
    end

    assign target_o = target_q;
endmodule

// File: rtl/vecarb_checker.sv
module vecarb_checker #(
    parameter int unsigned ADDR_W   = 15,
    parameter int unsigned NUM_MASK = 13
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic [ADDR_W-1:0]   instr_addr_i,
    input logic [NUM_MASK-1:0] irq_en_i,
    input logic [NUM_MASK-1:0] irq_pend_i,
    input logic                trap_pend_i,
    input logic                mem_rd_o,
    input logic [ADDR_W-1:0]   mem_addr_o,
    input logic [7:0]          mem_rdata_i,
    input logic                busy_o,
    input logic                done_o,
    input logic [ADDR_W-1:0]   target_o
);
    localparam int unsigned PAGE_W = ADDR_W - 8;

    logic [PAGE_W-1:0] page_guess;
    assign page_guess = instr_addr_i[ADDR_W-1:8] + PAGE_W'(&instr_addr_i[7:0]);

    a_r1_no_read_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_rd_o && !done_o));

    a_r2_done_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    a_r4_offset_in_table: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_o) |-> (mem_addr_o[7:5] == 3'b111 && mem_addr_o[7:0] != 8'hFC));

    a_r5_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_o) && trap_pend_i) |=> mem_addr_o[7:0] == 8'hFE);

    a_r6_default_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_o) && !trap_pend_i && ((irq_en_i & irq_pend_i) == '0))
        |=> mem_addr_o[7:0] == 8'hE0);

    a_r7_page_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |=> mem_addr_o[ADDR_W-1:8] == $past(page_guess, 2));

    a_r8_even_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_o) |-> !mem_addr_o[0]);

    a_r8_odd_second: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_o) |=> (mem_rd_o && mem_addr_o == $past(mem_addr_o) + 1'b1));

    a_r8_two_reads_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && $past(mem_rd_o)) |=> !mem_rd_o);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_target_stable: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> $stable(target_o));
endmodule

bind vecarb_top vecarb_checker #(.ADDR_W(ADDR_W), .NUM_MASK(NUM_MASK)) chk_i (.*);

// File: tb/vecarb_top_tb_top.sv
`timescale 1ns/1ps
module vecarb_top_tb_top;
    localparam int AW = 15;
    localparam int NM = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] instr_addr_i = '0;
    logic [NM-1:0] irq_en_i = '0;
    logic [NM-1:0] irq_pend_i = '0;
    logic          trap_pend_i = 1'b0;
    logic          mem_rd_o;
    logic [AW-1:0] mem_addr_o;
    logic [7:0]    mem_rdata_i = 8'h00;
    logic          busy_o;
    logic          done_o;
    logic [AW-1:0] target_o;

    int checks = 0;
    int failures = 0;
    int rd_cnt = 0;
    int done_cnt = 0;
    logic [AW-1:0] rd_log [4];
    bit finished = 0;

    always #2.5 clk = ~clk;

    vecarb_top #(.ADDR_W(AW), .NUM_MASK(NM)) dut_i (.*);

    function automatic logic [7:0] memf(input logic [AW-1:0] a);
        if (a[0]) return a[7:0] ^ 8'h5A ^ {1'b0, a[14:8]};
        return {1'b1, a[14:8]};
    endfunction

    // memory model, one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd_o) mem_rdata_i <= memf(mem_addr_o);
        else          mem_rdata_i <= 8'hC3;
    end

    always @(negedge clk) begin
        if (rst_n && mem_rd_o) begin
            if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr_o;
            rd_cnt++;
        end
        if (rst_n && done_o) done_cnt++;
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_vis(input logic [AW-1:0] addr, input logic [NM-1:0] en,
                           input logic [NM-1:0] pend, input logic trap,
                           input logic [7:0] exp_off, input string tag, input bit restart);
        logic [AW-9:0] exp_page;
        logic [AW-1:0] hi_a;
        logic [AW-1:0] exp_tgt;
        int w;
        exp_page = addr[14:8] + 7'(addr[7:0] == 8'hFF);
        hi_a     = {exp_page, exp_off};
        exp_tgt  = {memf(hi_a)[6:0], memf(hi_a | 15'h1)};
        @(negedge clk);
        rd_cnt = 0; done_cnt = 0;
        start_i = 1'b1; instr_addr_i = addr;
        irq_en_i = en; irq_pend_i = pend; trap_pend_i = trap;
        @(negedge clk);                 // start accepted, now sampling cycle
        start_i = 1'b0;
        @(negedge clk);                 // selection taken: disturb the inputs (R3)
        irq_en_i = '1; irq_pend_i = '1; trap_pend_i = ~trap;
        instr_addr_i = ~addr;
        if (restart) start_i = 1'b1;    // R2: ignored while busy
        @(negedge clk);
        start_i = 1'b0;
        w = 0;
        while (!done_o && w < 40) begin
            @(negedge clk);
            w++;
        end
        check(done_o == 1'b1, "R9 done pulse", 32'(done_o), 32'd1);
        check(target_o == exp_tgt, {"R9 target ", tag}, 32'(target_o), 32'(exp_tgt));
        check(rd_log[0] == hi_a, {"R7/offset ", tag}, 32'(rd_log[0]), 32'(hi_a));
        check(rd_log[1] == (hi_a | 15'h1), "R8 odd read", 32'(rd_log[1]), 32'(hi_a | 15'h1));
        trap_pend_i = 1'b0; irq_en_i = '0; irq_pend_i = '0;
        repeat (4) @(negedge clk);
        check(rd_cnt == 2, "R8 read count", 32'(rd_cnt), 32'd2);
        check(done_cnt == 1, "R2 done count", 32'(done_cnt), 32'd1);
        check(busy_o == 1'b0, "R2 idle after done", 32'(busy_o), 32'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(busy_o == 1'b0, "R1 busy", 32'(busy_o), 32'd0);
        check(done_o == 1'b0, "R1 done", 32'(done_o), 32'd0);
        check(mem_rd_o == 1'b0, "R1 mem_rd", 32'(mem_rd_o), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(busy_o == 1'b0 && mem_rd_o == 1'b0, "R1 after release", 32'(busy_o), 32'd0);
    endtask

    task automatic t_each_source();   // R4
        for (int j = 0; j < NM; j++) begin
            run_vis(15'h0140, '1, NM'(1) << j, 1'b0, 8'hE2 + 8'(2 * j), "R4 single", 1'b0);
        end
    endtask

    task automatic t_multi();         // R4
        run_vis(15'h0305, '1, 13'h0421, 1'b0, 8'hF6, "R4 multi", 1'b0);
        run_vis(15'h0305, '1, 13'h1FFF, 1'b0, 8'hFA, "R4 all", 1'b0);
    endtask

    task automatic t_mask();          // R6
        run_vis(15'h0210, 13'h0005, 13'h1FFF, 1'b0, 8'hE6, "R6 masked", 1'b0);
        run_vis(15'h0210, 13'h0000, 13'h1FFF, 1'b0, 8'hE0, "R6 no enable", 1'b0);
        run_vis(15'h0210, 13'h1FFF, 13'h0000, 1'b0, 8'hE0, "R6 none pending", 1'b0);
    endtask

    task automatic t_trap();          // R5
        run_vis(15'h00FF, '1, '1, 1'b1, 8'hFE, "R5 trap over all", 1'b0);
        run_vis(15'h0420, '0, '0, 1'b1, 8'hFE, "R5 trap alone", 1'b0);
    endtask

    task automatic t_page();          // R7
        run_vis(15'h01FF, '1, 13'h0080, 1'b0, 8'hF0, "R7 last byte", 1'b0);
        run_vis(15'h7FFF, '1, 13'h0001, 1'b0, 8'hE2, "R7 wrap", 1'b0);
        run_vis(15'h02DF, '1, 13'h0100, 1'b0, 8'hF2, "R7 same page", 1'b0);
    endtask

    task automatic t_sample();        // R3
        run_vis(15'h0123, 13'h0001, 13'h0001, 1'b0, 8'hE2, "R3 late change", 1'b0);
    endtask

    task automatic t_busy_ignore();   // R2
        run_vis(15'h0555, '1, 13'h0010, 1'b0, 8'hEA, "R2 restart", 1'b1);
    endtask

    initial begin
        #(5.0 * 100000);
        failures++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        t_reset();
        t_each_source();
        t_multi();
        t_mask();
        t_trap();
        t_page();
        t_sample();
        t_busy_ignore();
        summary();
    end
endmodule